// File: doc/BRIEF.md
# Odd-Syndrome Calculator on Minimal-Polynomial Remainders

This block takes a received binary BCH word one bit per cycle, highest-degree coefficient first, and produces the odd syndromes S1, S3, … S(2T−1). It does not evaluate the word at each root with constant field multipliers. Each odd index i has its own small shift register. That register keeps the remainder of the word modulo the minimal polynomial of α^i. At the last bit, a fixed XOR network maps the remainder from the power basis {1, α^i, α^2i, …} into the standard basis of GF(2^M). The syndromes are ready in the same number of cycles as the word has bits. The word is not re-encoded first.

The same registers also serve as a systematic encoder. In encode mode every section runs as a recursive filter on the inverse of its minimal polynomial. The sections are chained, so the output of one feeds the next. While the parity bits are produced, the input of the chain is the XOR of all section feedbacks. This drives the output of the whole cascade to zero, which makes the emitted word a multiple of the generator polynomial. The field degree, the primitive polynomial, the number of odd syndromes and the word length are parameters. The minimal polynomials and the transform columns are computed at elaboration time.

Top module: `bch_msyn`

## Requirements
- R1: While reset is high, and in the cycle after it, `done` and `code_vld` are 0 and `syndromes` is all zero.
- R2: In syndrome mode (`mode`=0), once N bits have been accepted, `done` is 1 for exactly one cycle. That cycle follows the edge that accepted the last bit. The first accepted bit is the coefficient of x^(N−1). Slot j (`syndromes[j*M +: M]`) holds r(α^(2j+1)). Bit b of a slot is the coefficient of α^b, where α is a root of PRIM (x^4+x+1 by default).
- R3: Cycles with `in_valid` low are not counted, and their `in_bit` values do not affect any result.
- R4: `start` clears `syndromes` and the bit count on the next edge and samples `mode`. If `start` and `in_valid` are both high, `start` wins and that bit is dropped.
- R5: After completion, `syndromes` keep their value until the next `start`.
- R6: Bits offered while no word is in progress (no `start` since the last completion or reset) are ignored. They raise neither `done` nor `code_vld`.
- R7: In encode mode (`mode`=1), each accepted bit gives `code_vld`=1 one cycle later, together with its `code_bit`. The first K code bits equal the input bits, where K = N − R (7 by default). `done` also pulses after the N-th accepted bit.
- R8: In encode mode, the last R code bits are parity. R is the sum of the minimal-polynomial degrees (8 by default). These bits do not depend on the `in_bit` values offered in those positions, and the full N-bit word has all-zero syndromes. The syndrome outputs stay cleared in encode mode.
- R9: A codeword with 1 to T flipped bits gives a syndrome vector with at least one nonzero slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new word and sample `mode` |
| mode | input | 1 | 0 = syndrome computation, 1 = encode |
| in_valid | input | 1 | `in_bit` is a word bit this cycle |
| in_bit | input | 1 | Received or message bit, highest degree first |
| code_bit | output | 1 | Encoded bit, registered |
| code_vld | output | 1 | `code_bit` is valid |
| done | output | 1 | One-cycle pulse after the N-th accepted bit |
| syndromes | output | T*M | Odd syndromes, slot j is S(2j+1) |

## Verification
The bench model applies inputs at the rising edge, exactly as the design does. For each accepted encode bit it predicts `code_vld` and the message `code_bit` in the very next cycle. It predicts `done` and the new syndromes in the cycle after the edge that takes the N-th bit. Everywhere else it predicts the held or cleared values. Outputs are compared at every falling edge against this prediction, so a result that comes one cycle early or late is caught. Reference syndromes come from table-based Horner evaluation of r(α^i). Encoded words are fed back in syndrome mode and checked for zero syndromes, both as they are and with up to T injected errors.

// File: rtl/bch_msyn_pkg.sv
package bch_msyn_pkg;

   localparam int MAXM = 16;

   typedef enum logic {
      SYND_MODE = 1'b0,
      ENC_MODE  = 1'b1
   } msyn_mode_e;

   // product of two field elements, standard basis, modulo prim
   function automatic logic [MAXM-1:0] gf_mul(input logic [MAXM-1:0] a,
                                              input logic [MAXM-1:0] b,
                                              input int m,
                                              input logic [MAXM:0] prim);
      logic [MAXM:0] acc;
      acc = '0;
      for (int k = MAXM - 1; k >= 0; k--) begin
         if (k < m) begin
            acc = acc << 1;
            if (acc[m]) acc = acc ^ prim;
            if (b[k]) acc = acc ^ {1'b0, a};
         end
      end
      return acc[MAXM-1:0];
   endfunction

   // alpha^e by square and multiply
   function automatic logic [MAXM-1:0] gf_pow(input int e, input int m,
                                              input logic [MAXM:0] prim);
      logic [MAXM-1:0] res;
      logic [MAXM-1:0] base;
      int ee;
      ee   = e % ((1 << m) - 1);
      res  = MAXM'(1);
      base = MAXM'(2);
      for (int k = 0; k < 31; k++) begin
         if (((ee >> k) & 1) == 1) res = gf_mul(res, base, m, prim);
         base = gf_mul(base, base, m, prim);
      end
      return res;
   endfunction

   // size of the cyclotomic class of i, equal to the minimal-polynomial degree
   function automatic int cyc_len(input int i, input int m);
      int nn, j, i0, cnt;
      bit fin;
      nn  = (1 << m) - 1;
      i0  = i % nn;
      j   = i0;
      cnt = 0;
      fin = 1'b0;
      for (int s = 0; s < MAXM; s++) begin
         if (!fin) begin
            cnt++;
            j = (2 * j) % nn;
            if (j == i0) fin = 1'b1;
         end
      end
      return cnt;
   endfunction

   // binary coefficients of the minimal polynomial of alpha^i, bit k = x^k
   function automatic logic [MAXM:0] minpoly(input int i, input int m,
                                             input logic [MAXM:0] prim);
      logic [MAXM-1:0] c [MAXM+1];
      logic [MAXM-1:0] beta;
      logic [MAXM:0]   p;
      int nn, j, i0;
      bit fin;
      nn  = (1 << m) - 1;
      i0  = i % nn;
      j   = i0;
      fin = 1'b0;
      for (int k = 0; k <= MAXM; k++) c[k] = '0;
      c[0] = MAXM'(1);
      for (int s = 0; s < MAXM; s++) begin
         if (!fin) begin
            beta = gf_pow(j, m, prim);
            for (int k = MAXM; k >= 1; k--)
               c[k] = c[k-1] ^ gf_mul(beta, c[k], m, prim);
            c[0] = gf_mul(beta, c[0], m, prim);
            j = (2 * j) % nn;
            if (j == i0) fin = 1'b1;
         end
      end
      for (int k = 0; k <= MAXM; k++) p[k] = c[k][0];
      return p;
   endfunction

   // number of parity bits: sum of degrees of the first t odd classes
   function automatic int parity_len(input int t, input int m);
      int sum;
      sum = 0;
      for (int g = 0; g < t; g++) sum += cyc_len(2 * g + 1, m);
      return sum;
   endfunction

endpackage

// File: rtl/bch_msyn_ctrl.sv
module bch_msyn_ctrl
   import bch_msyn_pkg::*;
#(
   parameter int N = 15,
   parameter int K = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic mode,
   input  logic in_valid,
   output logic busy,
   output logic mode_q,
   output logic accept,
   output logic last,
   output logic parity_ph,
   output logic done
);
   localparam int CW = $clog2(N + 1);

   logic [CW-1:0] cnt;

   assign accept    = busy & in_valid & ~start;
   assign last      = accept & (cnt == CW'(N - 1));
   assign parity_ph = (mode_q == ENC_MODE) & (cnt >= CW'(K));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
         mode_q <= SYND_MODE;
      end else begin
         done <= last;
         if (start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            mode_q <= mode;
         end else if (accept) begin
            cnt <= cnt + CW'(1);
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bch_msyn_section.sv
module bch_msyn_section #(
   parameter int            M    = 4,
   parameter int            DEG  = 4,
   parameter logic [M:0]    POLY = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         enc_step,
   input  logic         syn_step,
   input  logic         rx_bit,
   input  logic         chain_in,
   output logic         chain_out,
   output logic         fb,
   output logic [M-1:0] rem_nxt
);
   localparam logic [M-1:0] MASK = (DEG >= M) ? '1 : M'((1 << DEG) - 1);

   logic [M-1:0] st;
   logic [M-1:0] enc_nxt;
   logic [M:0]   dv;

   // recursive-filter feedback: taps weighted by the reversed coefficients
   always_comb begin
      fb = 1'b0;
      for (int j = 1; j <= DEG; j++) fb = fb ^ (POLY[DEG-j] & st[j-1]);
   end

   assign chain_out = chain_in ^ fb;
   assign enc_nxt   = {st[M-2:0], chain_out} & MASK;

   // remainder update: multiply by x, add the bit, reduce once
   always_comb begin
      dv = {st, rx_bit};
      if (dv[DEG]) dv = dv ^ POLY;
      rem_nxt = dv[M-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst || clr)    st <= '0;
      else if (enc_step) st <= enc_nxt;
      else if (syn_step) st <= rem_nxt;
   end
endmodule

// File: rtl/bch_msyn_xform.sv
module bch_msyn_xform
   import bch_msyn_pkg::*;
#(
   parameter int M    = 4,
   parameter int IDX  = 1,
   parameter int DEG  = 4,
   parameter int PRIM = 'h13
) (
   input  logic [M-1:0] rem,
   output logic [M-1:0] sym
);
   localparam logic [MAXM:0] PRIM_V = (MAXM+1)'(PRIM);

   logic [M-1:0] col [DEG];

   for (genvar j = 0; j < DEG; j++) begin : g_col
      localparam logic [MAXM-1:0] CJ = gf_pow(IDX * j, M, PRIM_V);
      assign col[j] = CJ[M-1:0];
   end

   always_comb begin
      sym = '0;
      for (int j = 0; j < DEG; j++)
         if (rem[j]) sym = sym ^ col[j];
   end
endmodule

// File: rtl/bch_msyn.sv
module bch_msyn
   import bch_msyn_pkg::*;
#(
   parameter int M    = 4,
   parameter int PRIM = 'h13,
   parameter int T    = 2,
   parameter int N    = 15
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           mode,
   input  logic           in_valid,
   input  logic           in_bit,
   output logic           code_bit,
   output logic           code_vld,
   output logic           done,
   output logic [T*M-1:0] syndromes
);
   localparam logic [MAXM:0] PRIM_V = (MAXM+1)'(PRIM);
   localparam int NN = (1 << M) - 1;
   localparam int R  = parity_len(T, M);
   localparam int K  = N - R;

   if (M < 3 || M > MAXM) begin : g_bad_m
      $error("field degree out of range");
   end
   if (N > NN) begin : g_bad_n
      $error("word longer than the field allows");
   end
   if (K < 1) begin : g_bad_k
      $error("no message bits left after parity");
   end
   if (2 * T - 1 >= NN) begin : g_bad_t
      $error("too many syndromes for the field");
   end

   logic busy, mode_q, accept, last, parity_ph;
   logic enc_step, syn_step;
   logic [T-1:0] fb;
   logic [T:0]   chain;
   logic         c_bit;

   bch_msyn_ctrl #(.N(N), .K(K)) u_ctrl (
      .clk(clk), .rst(rst), .start(start), .mode(mode), .in_valid(in_valid),
      .busy(busy), .mode_q(mode_q), .accept(accept), .last(last),
      .parity_ph(parity_ph), .done(done)
   );

   assign enc_step = accept & (mode_q == ENC_MODE);
   assign syn_step = accept & (mode_q == SYND_MODE);
   assign c_bit    = parity_ph ? (^fb) : in_bit;
   assign chain[0] = c_bit;

   for (genvar g = 0; g < T; g++) begin : g_sec
      localparam int            IDX = 2 * g + 1;
      localparam int            DEG = cyc_len(IDX, M);
      localparam logic [MAXM:0] MP  = minpoly(IDX, M, PRIM_V);

      logic [M-1:0] rem_nxt, sym, syn_r;

      bch_msyn_section #(.M(M), .DEG(DEG), .POLY(MP[M:0])) u_sec (
         .clk(clk), .rst(rst), .clr(start), .enc_step(enc_step),
         .syn_step(syn_step), .rx_bit(in_bit), .chain_in(chain[g]),
         .chain_out(chain[g+1]), .fb(fb[g]), .rem_nxt(rem_nxt)
      );

      bch_msyn_xform #(.M(M), .IDX(IDX), .DEG(DEG), .PRIM(PRIM)) u_xf (
         .rem(rem_nxt), .sym(sym)
      );

      always_ff @(posedge clk) begin
         if (rst || start)           syn_r <= '0;
         else if (syn_step && last)  syn_r <= sym;
      end

      assign syndromes[g*M +: M] = syn_r;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code_vld <= 1'b0;
         code_bit <= 1'b0;
      end else begin
         code_vld <= enc_step;
         code_bit <= c_bit;
      end
   end
endmodule

// File: rtl/bch_msyn_chk.sv
module bch_msyn_chk
   import bch_msyn_pkg::*;
#(
   parameter int M = 4,
   parameter int T = 2
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic           in_valid,
   input logic           busy,
   input logic           mode_q,
   input logic           done,
   input logic           code_vld,
   input logic [T*M-1:0] syndromes
);
   logic rst_q = 1'b0;
   always @(posedge clk) rst_q <= rst;

   always @(negedge clk) begin
      if (rst_q) begin
         assert_reset_R1: assert (!done && !code_vld && syndromes == '0)
            else $error("outputs not cleared by reset");
      end
   end

   assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done longer than one cycle");

   assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      start |=> (syndromes == '0 && !done)) else $error("start did not clear");

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!start && !busy) |=> $stable(syndromes)) else $error("syndromes moved while idle");

   assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> (!done && !code_vld)) else $error("activity while idle");

   assert_enc_vld_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && in_valid && !start && mode_q == ENC_MODE) |=> code_vld)
      else $error("encoded bit missing");
endmodule

bind bch_msyn bch_msyn_chk #(.M(M), .T(T)) u_chk (
   .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .busy(busy),
   .mode_q(mode_q), .done(done), .code_vld(code_vld), .syndromes(syndromes)
);

// File: tb/bch_msyn_test.sv
module bch_msyn_test;
   localparam int M    = 4;
   localparam int PRIM = 'h13;
   localparam int T    = 2;
   localparam int N    = 15;
   localparam int R    = 8;
   localparam int K    = N - R;
   localparam int NN   = (1 << M) - 1;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0;
   logic in_valid = 1'b0, in_bit = 1'b0;
   logic code_bit, code_vld, done;
   logic [T*M-1:0] syndromes;

   bch_msyn #(.M(M), .PRIM(PRIM), .T(T), .N(N)) uut (
      .clk(clk), .rst(rst), .start(start), .mode(mode), .in_valid(in_valid),
      .in_bit(in_bit), .code_bit(code_bit), .code_vld(code_vld), .done(done),
      .syndromes(syndromes)
   );

   always #10 clk = ~clk;

   int    gexp [NN];
   int    glog [NN+1];
   int    n_chk = 0, n_fail = 0, cycles = 0;
   string tag = "R1";

   function automatic int fmul(int a, int b);
      if (a == 0 || b == 0) return 0;
      return gexp[(glog[a] + glog[b]) % NN];
   endfunction

   // Horner evaluation of r(alpha^i), first bit = highest degree
   function automatic int ref_syn(int i, int w[N]);
      int s, ai;
      s  = 0;
      ai = gexp[i % NN];
      for (int p = 0; p < N; p++) s = fmul(s, ai) ^ w[p];
      return s;
   endfunction

   task automatic chk(bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural model, advanced on the same edge the design samples
   bit m_busy, m_enc, m_done, m_cvld, m_cchk, m_cexp;
   int m_cnt;
   int m_word [N];
   int m_syn  [T];

   always @(posedge clk) begin
      m_done = 0; m_cvld = 0; m_cchk = 0;
      if (rst) begin
         m_busy = 0; m_cnt = 0; m_enc = 0;
         for (int j = 0; j < T; j++) m_syn[j] = 0;
      end else if (start) begin
         m_busy = 1; m_cnt = 0; m_enc = mode;
         for (int j = 0; j < T; j++) m_syn[j] = 0;
      end else if (m_busy && in_valid) begin
         if (m_enc) begin
            m_cvld = 1; m_cchk = (m_cnt < K); m_cexp = in_bit;
         end
         m_word[m_cnt] = int'(in_bit);
         m_cnt++;
         if (m_cnt == N) begin
            m_busy = 0; m_done = 1;
            if (!m_enc)
               for (int j = 0; j < T; j++) m_syn[j] = ref_syn(2 * j + 1, m_word);
         end
      end
   end

   int cw [N];
   int cw_idx = 0;

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      cycles++;
      chk(done == m_done, "done (R2/R7)", int'(done), int'(m_done));
      chk(code_vld == m_cvld, "code_vld (R7)", int'(code_vld), int'(m_cvld));
      if (m_cchk) chk(code_bit == m_cexp, "message code bit (R7)", int'(code_bit), int'(m_cexp));
      for (int j = 0; j < T; j++)
         chk(int'(syndromes[j*M +: M]) == m_syn[j], "syndrome slot (R2)",
             int'(syndromes[j*M +: M]), m_syn[j]);
      if (code_vld && cw_idx < N) begin
         cw[cw_idx] = int'(code_bit);
         cw_idx++;
      end
      if (cycles > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 20000);
         summary();
      end
   end

   task automatic idle(int c);
      in_valid = 0;
      repeat (c) @(negedge clk);
   endtask

   task automatic do_start(bit md);
      start = 1; mode = md; in_valid = 0;
      @(negedge clk);
      start = 0;
      cw_idx = 0;
   endtask

   task automatic feed(int w[N], bit gaps);
      for (int p = 0; p < N; p++) begin
         if (gaps && (p % 3 == 1)) begin
            in_valid = 0; in_bit = 1'($urandom);
            @(negedge clk);
         end
         in_valid = 1; in_bit = w[p][0];
         @(negedge clk);
      end
      in_valid = 0;
   endtask

   function automatic bit all_zero();
      return syndromes == '0;
   endfunction

   int w [N];
   int msg [N];
   int cw1 [N];

   initial begin
      int x;
      x = 1;
      for (int e = 0; e < NN; e++) begin
         gexp[e] = x; glog[x] = e;
         x = x << 1;
         if ((x & (1 << M)) != 0) x = x ^ PRIM;
      end

      repeat (3) @(negedge clk);
      rst = 0;
      // R1: reset state
      chk(!done && !code_vld && syndromes == '0, "reset state R1", int'(syndromes), 0);

      // R2: plain received words
      tag = "R2";
      for (int rep = 0; rep < 4; rep++) begin
         for (int p = 0; p < N; p++) w[p] = int'($urandom % 2);
         do_start(0); feed(w, 0); idle(2);
      end
      for (int p = 0; p < N; p++) w[p] = (p == 0) ? 1 : 0;
      do_start(0); feed(w, 0); idle(2);

      // R3: stalls with garbage on the data line
      tag = "R3";
      for (int p = 0; p < N; p++) w[p] = int'($urandom % 2);
      do_start(0); feed(w, 1); idle(2);

      // R5: results held while idle
      tag = "R5";
      idle(8);

      // R6: bits without start
      tag = "R6";
      feed(w, 0); idle(3);

      // R4: restart mid-word, start colliding with a valid bit
      tag = "R4";
      do_start(0);
      chk(all_zero(), "cleared by start R4", int'(syndromes), 0);
      for (int p = 0; p < 5; p++) begin in_valid = 1; in_bit = 1; @(negedge clk); end
      start = 1; in_valid = 1; in_bit = 1; mode = 0;
      @(negedge clk);
      start = 0; in_valid = 0;
      for (int p = 0; p < N; p++) w[p] = int'($urandom % 2);
      feed(w, 0); idle(2);

      // R7: encode a message, parity slots carry junk
      tag = "R7";
      for (int p = 0; p < N; p++) msg[p] = (p < K) ? int'($urandom % 2) : int'($urandom % 2);
      do_start(1); feed(msg, 0); idle(2);
      chk(cw_idx == N, "code bit count R7", cw_idx, N);
      for (int p = 0; p < N; p++) cw1[p] = cw[p];

      // R8: parity independent of junk, codeword syndromes zero
      tag = "R8";
      chk(all_zero(), "syndromes stay cleared in encode R8", int'(syndromes), 0);
      for (int p = K; p < N; p++) msg[p] = 1 - msg[p];
      do_start(1); feed(msg, 0); idle(2);
      for (int p = 0; p < N; p++)
         chk(cw[p] == cw1[p], "parity ignores input R8", cw[p], cw1[p]);
      do_start(0); feed(cw1, 0); idle(1);
      chk(all_zero(), "codeword syndromes zero R8", int'(syndromes), 0);
      for (int rep = 0; rep < 3; rep++) begin
         for (int p = 0; p < N; p++) msg[p] = int'($urandom % 2);
         do_start(1); feed(msg, 0); idle(2);
         for (int p = 0; p < N; p++) w[p] = cw[p];
         do_start(0); feed(w, 0); idle(1);
         chk(all_zero(), "codeword syndromes zero R8", int'(syndromes), 0);
      end

      // R9: one to T errors are always seen
      tag = "R9";
      for (int rep = 0; rep < 6; rep++) begin
         int e1, e2;
         e1 = int'($urandom % N);
         e2 = (e1 + 1 + int'($urandom % (N - 1))) % N;
         for (int p = 0; p < N; p++) w[p] = cw1[p];
         w[e1] = 1 - w[e1];
         if (rep % 2 == 1) w[e2] = 1 - w[e2];
         do_start(0); feed(w, 0); idle(1);
         chk(!all_zero(), "errors give nonzero syndromes R9", int'(syndromes), 1);
      end

      idle(3);
      summary();
   end
endmodule